// File: doc/BRIEF.md
# Pipelined Systolic Array Multiplier

This block multiplies two 4-bit unsigned operands in a grid of registered full adders. Each partial-product bit is the AND of one bit of `in_a` with one bit of `in_b`. A row of adders folds one row of partial products into a carry-save pair of sum and carry vectors. Sums move straight down to the next row and carries move one column to the left. After the last row, a chain of single-bit adder stages resolves the carries one column per cycle. Each result bit is therefore settled on its own cycle, starting with bit 1 and ending with bit 7.

An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The pair is held in one operand register, and each adder row reads its own `in_b` bit from that register on its own cycle. A fresh pair may enter only every third cycle, so the register stays stable until the last row has read it. The resolved bits travel with the operation and are collected into a single 8-bit product, which is presented for one cycle with `out_valid`. Up to four operations are in flight at once.

Top module: `sysmul_array`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it goes high, `out_valid` and `in_ready` are both 0. After that, an idle block shows `in_ready` = 1.
- R2: Every product equals the unsigned product of the accepted operands. `out_prod[i]` has weight 2^i, and `in_a[0]` and `in_b[0]` are the least significant operand bits.
- R3: After an accepting edge, `in_ready` is 0 for the next two cycles and returns to 1 in the third, provided no other request is pending. Accepting edges are therefore at least 3 edges apart.
- R4: A request made while `in_ready` is 0 is ignored: it yields no product and does not alter any other product.
- R5: `out_valid` is 1 for exactly one cycle per accepted operation, after exactly 10 rising edges counted from the accepting edge. Products leave in acceptance order.
- R6: N operations issued at the maximum rate finish with the last product 10 + 3(N-1) edges after the first accepting edge.
- R7: Operands are sampled only on the accepting edge; changing `in_a` or `in_b` afterwards has no effect on that product.
- R8: Corner operands give exact results: 0 times anything is 0, 15 x 15 = 225, and 14 x 11 = 154 (binary 1110 x 1011 = 10011010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request to start a multiplication |
| in_ready | output | 1 | High when a request on this cycle will be accepted |
| in_a | input | 4 | Multiplicand, unsigned |
| in_b | input | 4 | Multiplier, unsigned; bit j feeds adder row j |
| out_valid | output | 1 | One-cycle strobe marking a finished product |
| out_prod | output | 8 | Full 8-bit product |

## Verification
The bench drives pairs at the maximum rate of one every three cycles. This catches a block that lets the operand register change while a late adder row still needs it: the fourth partial-product row would then come from the next operation. A request held high through the busy window tests the refusal path. A block that accepts such a request would emit a spurious product, or damage the one in flight. Operands with all-ones and all-zero bits, and the worked example, exercise every carry column. A wrong carry direction or a missing final-carry stage would corrupt the high bits. Each product is also timed against its accepting edge, so an extra or missing register anywhere in the rows or the carry chain shows up as a wrong cycle.

// File: rtl/sysmul_pkg.sv
package sysmul_pkg;
  localparam int unsigned OPW = 4;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/sysmul_rst_sync.sv
module sysmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/sysmul_csa_row.sv
module sysmul_csa_row import sysmul_pkg::*; #(
  parameter int unsigned W  = OPW,
  parameter int unsigned SH = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_i,
  input  logic [2*W-1:0] s_i,
  input  logic [2*W-1:0] c_i,
  input  logic [W-1:0]   a_i,
  input  logic           b_i,
  output logic           v_o,
  output logic [2*W-1:0] s_o,
  output logic [2*W-1:0] c_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] pp;
  logic [PW-1:0] s_d;
  logic [PW-1:0] cg;
  logic [PW-1:0] c_d;

  // One row of full adders: vertical sum, diagonal carry, horizontal partial product.
  always_comb begin
    pp  = PW'(a_i & {W{b_i}}) << SH;
    s_d = s_i ^ c_i ^ pp;
    for (int k = 0; k < PW; k++) cg[k] = maj3(s_i[k], c_i[k], pp[k]);
    c_d = cg << 1;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      s_o <= s_d;
      c_o <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end
endmodule

// File: rtl/sysmul_ripple_stage.sv
module sysmul_ripple_stage import sysmul_pkg::*; #(
  parameter int unsigned PW = 2 * OPW,
  parameter int unsigned K  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic [PW-1:0] s_i,
  input  logic [PW-1:0] c_i,
  input  logic [PW-1:0] r_i,
  input  logic          cy_i,
  output logic          v_o,
  output logic [PW-1:0] s_o,
  output logic [PW-1:0] c_o,
  output logic [PW-1:0] r_o,
  output logic          cy_o
);
  logic [PW-1:0] r_d;
  logic          cy_d;

  // Settles column K; the result vector carries the already settled bits along.
  always_comb begin
    r_d    = r_i;
    r_d[K] = s_i[K] ^ c_i[K] ^ cy_i;
    cy_d   = maj3(s_i[K], c_i[K], cy_i);
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      s_o  <= s_i;
      c_o  <= c_i;
      r_o  <= r_d;
      cy_o <= cy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end
endmodule

// File: rtl/sysmul_array.sv
module sysmul_array import sysmul_pkg::*; #(
  parameter int unsigned W = OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_prod
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned II = W - 1;
  localparam int unsigned GW = (II > 1) ? $clog2(II) : 1;

  logic rst_i;
  sysmul_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  // Issue spacing
  logic          accept;
  logic [GW-1:0] gap_q;
  logic [GW-1:0] gap_d;

  assign accept = in_valid && in_ready;

  always_comb begin
    gap_d = gap_q;
    if (accept)              gap_d = GW'(II - 1);
    else if (gap_q != '0)    gap_d = gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  assign in_ready = rst_i && (gap_q == '0);

  // Operand skew buffer: row r reads bit r of b on the r-th edge after acceptance
  logic [W-1:0] op_a_q;
  logic [W-1:0] op_b_q;
  logic         op_v_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      op_a_q <= in_a;
      op_b_q <= in_b;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) op_v_q <= 1'b0;
    else        op_v_q <= accept;
  end

  // Adder grid
  logic [PW-1:0] row_s [W];
  logic [PW-1:0] row_c [W];
  logic          row_v [W];

  assign row_s[0] = PW'(op_a_q & {W{op_b_q[0]}});
  assign row_c[0] = '0;
  assign row_v[0] = op_v_q;

  for (genvar r = 1; r < W; r++) begin : g_row
    sysmul_csa_row #(.W(W), .SH(r)) u_row (
      .clk(clk), .rst_n(rst_i),
      .v_i(row_v[r-1]), .s_i(row_s[r-1]), .c_i(row_c[r-1]),
      .a_i(op_a_q), .b_i(op_b_q[r]),
      .v_o(row_v[r]), .s_o(row_s[r]), .c_o(row_c[r])
    );
  end

  // Staggered carry resolution with deskew
  logic [PW-1:0] rp_s  [PW];
  logic [PW-1:0] rp_c  [PW];
  logic [PW-1:0] rp_r  [PW];
  logic          rp_cy [PW];
  logic          rp_v  [PW];

  assign rp_s[0]  = row_s[W-1];
  assign rp_c[0]  = row_c[W-1];
  assign rp_r[0]  = PW'(row_s[W-1][0]);
  assign rp_cy[0] = 1'b0;
  assign rp_v[0]  = row_v[W-1];

  for (genvar k = 1; k < PW; k++) begin : g_rip
    sysmul_ripple_stage #(.PW(PW), .K(k)) u_stage (
      .clk(clk), .rst_n(rst_i),
      .v_i(rp_v[k-1]), .s_i(rp_s[k-1]), .c_i(rp_c[k-1]),
      .r_i(rp_r[k-1]), .cy_i(rp_cy[k-1]),
      .v_o(rp_v[k]), .s_o(rp_s[k]), .c_o(rp_c[k]),
      .r_o(rp_r[k]), .cy_o(rp_cy[k])
    );
  end

  assign out_valid = rp_v[PW-1];
  assign out_prod  = rp_r[PW-1];
endmodule

// File: rtl/sysmul_array_chk.sv
module sysmul_array_chk #(
  parameter int unsigned W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic [2*W-1:0] out_prod
);
  localparam int unsigned LAT  = 3 * W - 2;
  localparam int unsigned OW   = $clog2(LAT) + 2;
  localparam logic [2*W-1:0] MAXP = (2*W)'(((1 << W) - 1) * ((1 << W) - 1));

  logic          acc;
  logic [OW-1:0] outst_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= outst_q + OW'(acc) - OW'(out_valid);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid && !in_ready)
        else $error("R1 outputs active during reset");
    end
  end

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_prod <= MAXP));

  p_no_orphan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (outst_q != '0));

  if (W >= 3) begin : g_gap1
    p_gap1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !in_ready);
    p_out_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
  end

  if (W >= 4) begin : g_gap2
    p_gap2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ##1 !in_ready);
  end
endmodule

bind sysmul_array sysmul_array_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/sysmul_array_bench.sv
module sysmul_array_bench;
  localparam int W   = 4;
  localparam int LAT = 10;
  localparam int II  = 3;
  localparam int NV  = 16;
  // {a, b, expected product}
  localparam logic [15:0] VEC [NV] = '{
    {4'd14, 4'd11, 8'd154}, {4'd0,  4'd0,  8'd0},   {4'd15, 4'd15, 8'd225},
    {4'd1,  4'd1,  8'd1},   {4'd0,  4'd15, 8'd0},   {4'd15, 4'd0,  8'd0},
    {4'd7,  4'd9,  8'd63},  {4'd8,  4'd8,  8'd64},  {4'd5,  4'd13, 8'd65},
    {4'd12, 4'd3,  8'd36},  {4'd9,  4'd14, 8'd126}, {4'd6,  4'd10, 8'd60},
    {4'd11, 4'd4,  8'd44},  {4'd3,  4'd5,  8'd15},  {4'd13, 4'd13, 8'd169},
    {4'd2,  4'd15, 8'd30}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_a = '0;
  logic [3:0] in_b = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_prod;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    wr = 0;
  int    rd = 0;
  int    exp_p [512];
  int    acc_c [512];
  string tag   [512];
  int    last_out = 0;
  int    last_prod = 0;

  sysmul_array #(.W(W)) u_sysmul_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Result monitor: R2/R8 values, R5 timing and ordering, R4 no stray products
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        chk(1'b0, "R4 stray out_valid", int'(out_prod), -1);
      end else begin
        chk(int'(out_prod) == exp_p[rd], tag[rd], int'(out_prod), exp_p[rd]);
        chk(cyc == acc_c[rd] + LAT, "R5 latency", cyc - acc_c[rd], LAT);
        last_out  = cyc;
        last_prod = int'(out_prod);
        rd++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic issue(input logic [3:0] a, input logic [3:0] b, input int expv, input string req);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_a      = a;
    in_b      = b;
    exp_p[wr] = expv;
    acc_c[wr] = cyc + 1;
    tag[wr]   = req;
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    int first_acc;
    // R1: reset behaviour
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    chk(!in_ready, "R1 in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready, "R1 in_ready one edge after release", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    chk(in_ready, "R1 in_ready idle", int'(in_ready), 1);
    chk(!out_valid, "R1 out_valid idle", int'(out_valid), 0);

    // Vector table at the maximum rate (R2, R8, R6)
    first_acc = cyc + 1;
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][15:12], VEC[i][11:8], int'(VEC[i][7:0]),
            (i < 6) ? "R8 corner product" : "R2 product");
    end
    drain();
    chk(rd == wr, "R6 all products seen", rd, wr);
    chk(last_out - first_acc == LAT + II * (NV - 1), "R6 burst length",
        last_out - first_acc, LAT + II * (NV - 1));

    // Random pairs at the maximum rate (R2)
    for (int i = 0; i < 40; i++) begin
      logic [3:0] ra;
      logic [3:0] rb;
      ra = 4'($urandom);
      rb = 4'($urandom);
      issue(ra, rb, int'(ra) * int'(rb), "R2 random product");
    end
    drain();
    chk(rd == wr, "R2 random count", rd, wr);

    // R3: ready window after one accept
    issue(4'd5, 4'd6, 30, "R2 product");
    chk(!in_ready, "R3 busy cycle 1", int'(in_ready), 0);
    @(negedge clk);
    chk(!in_ready, "R3 busy cycle 2", int'(in_ready), 0);
    @(negedge clk);
    chk(in_ready, "R3 ready again", int'(in_ready), 1);
    drain();

    // R4 and R7: request held while busy, operands changed after accept
    issue(4'd3, 4'd3, 9, "R7 product after operand change");
    in_valid = 1'b1;
    in_a     = 4'd15;
    in_b     = 4'd15;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk(rd == wr, "R4 refused request", rd, wr);
    chk(last_prod == 9, "R7 captured operands", last_prod, 9);

    // Irregular spacing with idle gaps (R5)
    issue(4'd15, 4'd14, 210, "R2 product");
    repeat (4) @(negedge clk);
    issue(4'd10, 4'd10, 100, "R2 product");
    drain();
    chk(rd == wr, "R5 one strobe per operation", rd, wr);

    summary();
    $finish;
  end
endmodule